// File: doc/BRIEF.md
# NAND Flash Host-Register Bridge

The bridge sits between a simple synchronous host bus and a bank of up to sixteen NAND flash devices. The devices share one IO bus and the command-latch, address-latch, read-strobe and write-strobe lines. Each device has its own active-low chip enable and its own ready/busy line. The host drives NAND command, address and data phases by writing or reading three separate register offsets. The bridge turns each such access into one NAND bus cycle and holds `wait_o` high until that cycle has fully finished.

A chip-select register picks the device whose enable is driven low. A status register returns all sixteen synchronized ready/busy lines in one word. Strobe low and high widths are parameters counted in clocks. The IO bus is presented as separate output, output-enable and input vectors, so that the pad ring can build the tri-state buffer. Page sequencing, ECC and bad-block handling stay in host software.

The host bus works as follows. The host raises `req_i` for one clock while `wait_o` is low, with `we_i`, `addr_i` and `wdata_i` valid in that clock. `rdata_o` holds the result of the last read until the next read completes.

Top module: `nand_host_bridge`

## Requirements
- R1: A host write to offset 0x0 gives a data-input cycle. WE# is low for exactly T_LO clocks, CLE and ALE stay 0 throughout, and `io_o` carries `wdata_i[IO_W-1:0]` for the whole cycle.
- R2: A host read from offset 0x0 gives a data-output cycle. RE# is low for T_LO clocks and WE# stays high. `io_i` is sampled in the last clock of the RE# low time, before RE# rises. `rdata_o` then holds that value, zero-extended.
- R3: A host write to offset 0x1 gives a command cycle. CLE is 1 from one clock before WE# falls until one clock or more after WE# rises. ALE stays 0.
- R4: A host write to offset 0x2 gives an address cycle. ALE is 1 over the same window that R3 gives for CLE. CLE stays 0, and CLE and ALE are never 1 together.
- R5: A host write to offset 0x0FFFFFFC sets the chip-select index to `wdata_i[3:0]`, one clock after the request. After that, exactly one `ce_n_o` bit is low: the bit at that index.
- R6: A host read from offset 0x0FFFFFF8 returns the ready/busy inputs in `rdata_o`, one clock after the request. Bit n of `rdata_o` is device n and the upper bits are 0. The inputs pass through a two-flop synchronizer before the status register sees them.
- R7: For a NAND cycle, `wait_o` rises one clock after the request and stays high for T_LO+T_HI+2 clocks. These are one setup clock, T_LO strobe-low clocks, T_HI strobe-high clocks and one hold clock. A request made while `wait_o` is high is ignored.
- R8: `io_oe_o` is 1 only during write-type NAND cycles (data, command, address) and is 0 at all other times.
- R9: Any other offset completes without any strobe, latch or wait. A read from it (this includes reads of 0x1, 0x2 and 0x0FFFFFFC) sets `rdata_o` to 0.
- R10: After reset, WE# and RE# are high, CLE, ALE, `wait_o` and `io_oe_o` are 0, `rdata_o` is 0, and device 0 is selected (`ce_n_o` = 0xFFFE).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | 1 | Host access request, one clock |
| we_i | input | 1 | 1 = host write, 0 = host read |
| addr_i | input | ADDR_W | Host byte offset |
| wdata_i | input | HOST_W | Host write data |
| rdata_o | output | HOST_W | Host read data, held until the next read |
| wait_o | output | 1 | High while a NAND cycle is in progress |
| ce_n_o | output | N_DEV | Per-device chip enable, active low |
| we_n_o | output | 1 | Shared write strobe, active low |
| re_n_o | output | 1 | Shared read strobe, active low |
| cle_o | output | 1 | Shared command latch enable |
| ale_o | output | 1 | Shared address latch enable |
| io_o | output | IO_W | IO bus output value |
| io_oe_o | output | 1 | IO bus output enable |
| io_i | input | IO_W | IO bus input value |
| rb_i | input | N_DEV | Per-device ready/busy, 1 = ready |

## Verification
Register accesses (chip select, status, undefined offsets) take effect one clock after the request. The bench reads their results at the falling edge that follows the capturing edge. For a NAND cycle, the bench samples every falling edge from the first to the (T_LO+T_HI+3)th after the request. At each one it compares wait, both strobes, both latches and the output enable against a per-clock shape computed from T_LO and T_HI. It also changes `io_i` in the clocks around the RE# rise, so that the captured read value shows which clock was sampled. Ready/busy changes are given three clocks to pass the synchronizer before the status register is read.

// File: rtl/nand_bridge_pkg.sv
package nand_bridge_pkg;
  typedef enum logic [2:0] {
    OP_NONE,
    OP_DWR,
    OP_DRD,
    OP_CMD,
    OP_ADR,
    OP_CSW,
    OP_STR
  } op_e;
endpackage

// File: rtl/nand_host_decode.sv
module nand_host_decode
  import nand_bridge_pkg::*;
#(
  parameter int ADDR_W = 28,
  parameter logic [ADDR_W-1:0] CS_OFS = 28'hFFFFFFC,
  parameter logic [ADDR_W-1:0] ST_OFS = 28'hFFFFFF8
) (
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  output op_e               op_o
);
  localparam logic [ADDR_W-1:0] DATA_OFS = '0;
  localparam logic [ADDR_W-1:0] CMD_OFS  = ADDR_W'(1);
  localparam logic [ADDR_W-1:0] ADR_OFS  = ADDR_W'(2);

  always_comb begin
    op_o = OP_NONE;
    if (we_i) begin
      if (addr_i == DATA_OFS)     op_o = OP_DWR;
      else if (addr_i == CMD_OFS) op_o = OP_CMD;
      else if (addr_i == ADR_OFS) op_o = OP_ADR;
      else if (addr_i == CS_OFS)  op_o = OP_CSW;
    end else begin
      if (addr_i == DATA_OFS)     op_o = OP_DRD;
      else if (addr_i == ST_OFS)  op_o = OP_STR;
    end
  end
endmodule

// File: rtl/nand_rb_sync.sv
module nand_rb_sync #(
  parameter int W = 16
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] s1_q, s2_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      s1_q <= '0;
      s2_q <= '0;
    end else begin
      s1_q <= d_i;
      s2_q <= s1_q;
    end
  end

  assign q_o = s2_q;
endmodule

// File: rtl/nand_cycle_engine.sv
module nand_cycle_engine
  import nand_bridge_pkg::*;
#(
  parameter int IO_W = 8,
  parameter int T_LO = 2,
  parameter int T_HI = 2
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            start_i,
  input  op_e             op_i,
  input  logic [IO_W-1:0] wdata_i,
  input  logic [IO_W-1:0] io_i,
  output logic            busy_o,
  output logic            we_n_o,
  output logic            re_n_o,
  output logic            cle_o,
  output logic            ale_o,
  output logic [IO_W-1:0] io_o,
  output logic            io_oe_o,
  output logic [IO_W-1:0] rd_data_o,
  output logic            rd_vld_o
);
  localparam int T_MAX = (T_LO > T_HI) ? T_LO : T_HI;
  localparam int CNT_W = $clog2(T_MAX + 1);

  typedef enum logic [2:0] {S_IDLE, S_SETUP, S_LOW, S_HIGH, S_HOLD} st_e;

  st_e              st_q;
  logic [CNT_W-1:0] cnt_q;
  op_e              op_q;
  logic [IO_W-1:0]  wd_q, rd_q;
  logic             vld_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q  <= S_IDLE;
      cnt_q <= '0;
      op_q  <= OP_NONE;
      wd_q  <= '0;
      rd_q  <= '0;
      vld_q <= 1'b0;
    end else begin
      vld_q <= 1'b0;
      case (st_q)
        S_IDLE: if (start_i) begin
          st_q <= S_SETUP;
          op_q <= op_i;
          wd_q <= wdata_i;
        end
        S_SETUP: begin
          st_q  <= S_LOW;
          cnt_q <= CNT_W'(T_LO - 1);
        end
        S_LOW: if (cnt_q == '0) begin
          st_q  <= S_HIGH;
          cnt_q <= CNT_W'(T_HI - 1);
          if (op_q == OP_DRD) begin
            rd_q  <= io_i;  // captured while RE# still low
            vld_q <= 1'b1;
          end
        end else cnt_q <= cnt_q - 1'b1;
        S_HIGH: if (cnt_q == '0) st_q <= S_HOLD;
                else cnt_q <= cnt_q - 1'b1;
        S_HOLD: st_q <= S_IDLE;
        default: st_q <= S_IDLE;
      endcase
    end
  end

  logic strobe_lo, is_rd;
  assign strobe_lo = (st_q == S_LOW);
  assign is_rd     = (op_q == OP_DRD);
  assign busy_o    = (st_q != S_IDLE);
  assign we_n_o    = !(strobe_lo && !is_rd);
  assign re_n_o    = !(strobe_lo && is_rd);
  assign cle_o     = busy_o && (op_q == OP_CMD);
  assign ale_o     = busy_o && (op_q == OP_ADR);
  assign io_oe_o   = busy_o && !is_rd;
  assign io_o      = wd_q;
  assign rd_data_o = rd_q;
  assign rd_vld_o  = vld_q;

  p_latch_setup_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(we_n_o) |-> ($past(cle_o) == cle_o && $past(ale_o) == ale_o));
  p_latch_hold_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(we_n_o) |=> ($past(cle_o) == cle_o && $past(ale_o) == ale_o));
  p_latch_excl_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(cle_o && ale_o));
  p_oe_not_read_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    io_oe_o |-> re_n_o);
  p_one_strobe_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    we_n_o || re_n_o);
endmodule

// File: rtl/nand_host_bridge.sv
module nand_host_bridge
  import nand_bridge_pkg::*;
#(
  parameter int ADDR_W = 28,
  parameter int HOST_W = 32,
  parameter int IO_W   = 8,
  parameter int N_DEV  = 16,
  parameter int T_LO   = 2,
  parameter int T_HI   = 2,
  parameter logic [ADDR_W-1:0] CS_OFS = 28'hFFFFFFC,
  parameter logic [ADDR_W-1:0] ST_OFS = 28'hFFFFFF8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_i,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [HOST_W-1:0] wdata_i,
  output logic [HOST_W-1:0] rdata_o,
  output logic              wait_o,
  output logic [N_DEV-1:0]  ce_n_o,
  output logic              we_n_o,
  output logic              re_n_o,
  output logic              cle_o,
  output logic              ale_o,
  output logic [IO_W-1:0]   io_o,
  output logic              io_oe_o,
  input  logic [IO_W-1:0]   io_i,
  input  logic [N_DEV-1:0]  rb_i
);
  localparam int CS_W = (N_DEV > 1) ? $clog2(N_DEV) : 1;

  op_e               op;
  logic              busy, accept, start, rd_vld;
  logic [IO_W-1:0]   rd_data;
  logic [N_DEV-1:0]  rb_s;
  logic [CS_W-1:0]   cs_q;
  logic [HOST_W-1:0] rdata_q;

  nand_host_decode #(.ADDR_W(ADDR_W), .CS_OFS(CS_OFS), .ST_OFS(ST_OFS)) u_dec (
    .we_i(we_i), .addr_i(addr_i), .op_o(op)
  );

  nand_rb_sync #(.W(N_DEV)) u_sync (
    .clk_i(clk_i), .rst_ni(rst_ni), .d_i(rb_i), .q_o(rb_s)
  );

  assign accept = req_i && !busy;
  assign start  = accept && (op == OP_DWR || op == OP_DRD || op == OP_CMD || op == OP_ADR);

  nand_cycle_engine #(.IO_W(IO_W), .T_LO(T_LO), .T_HI(T_HI)) u_eng (
    .clk_i(clk_i), .rst_ni(rst_ni), .start_i(start), .op_i(op),
    .wdata_i(wdata_i[IO_W-1:0]), .io_i(io_i), .busy_o(busy),
    .we_n_o(we_n_o), .re_n_o(re_n_o), .cle_o(cle_o), .ale_o(ale_o),
    .io_o(io_o), .io_oe_o(io_oe_o), .rd_data_o(rd_data), .rd_vld_o(rd_vld)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cs_q    <= '0;
      rdata_q <= '0;
    end else begin
      if (rd_vld) rdata_q <= HOST_W'(rd_data);
      if (accept) begin
        case (op)
          OP_CSW:  if (32'(wdata_i[CS_W-1:0]) < N_DEV) cs_q <= wdata_i[CS_W-1:0];
          OP_STR:  rdata_q <= HOST_W'(rb_s);
          OP_NONE: if (!we_i) rdata_q <= '0;
          default: ;
        endcase
      end
    end
  end

  for (genvar g = 0; g < N_DEV; g++) begin : g_ce
    assign ce_n_o[g] = (cs_q != CS_W'(g));
  end

  assign wait_o  = busy;
  assign rdata_o = rdata_q;

  p_strobe_in_wait_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!we_n_o || !re_n_o) |-> wait_o);
  p_ignore_busy_req_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wait_o && req_i) |=> ($stable(cs_q) && $stable(ce_n_o)));
  p_ce_single_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $countones(~ce_n_o) == 1);
  p_undef_no_wait_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && !wait_o && op == OP_NONE) |=> !wait_o);
  p_status_ret_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && !wait_o && op == OP_STR) |=> (rdata_o == HOST_W'($past(rb_s))));
endmodule

// File: tb/nand_host_bridge_bench.sv
module nand_host_bridge_bench;
  localparam int ADDR_W = 28;
  localparam int HOST_W = 32;
  localparam int IO_W   = 8;
  localparam int N_DEV  = 16;
  localparam int T_LO   = 3;
  localparam int T_HI   = 2;
  localparam int CYC    = T_LO + T_HI + 2;
  localparam logic [ADDR_W-1:0] A_CS = 28'hFFFFFFC;
  localparam logic [ADDR_W-1:0] A_ST = 28'hFFFFFF8;

  logic clk = 0, rst_n = 0;
  logic req = 0, we = 0;
  logic [ADDR_W-1:0] addr = '0;
  logic [HOST_W-1:0] wdata = '0;
  logic [HOST_W-1:0] rdata;
  logic wait_s, we_n, re_n, cle, ale, io_oe;
  logic [N_DEV-1:0] ce_n, rb = '0;
  logic [IO_W-1:0] io_out, io_in = '0;

  int total = 0, bad = 0;
  int exp_cs = 0;
  logic [HOST_W-1:0] exp_rd = '0;

  always #5 clk = ~clk;

  nand_host_bridge #(.ADDR_W(ADDR_W), .HOST_W(HOST_W), .IO_W(IO_W), .N_DEV(N_DEV),
    .T_LO(T_LO), .T_HI(T_HI), .CS_OFS(A_CS), .ST_OFS(A_ST)) u_nand_host_bridge (
    .clk_i(clk), .rst_ni(rst_n), .req_i(req), .we_i(we), .addr_i(addr),
    .wdata_i(wdata), .rdata_o(rdata), .wait_o(wait_s), .ce_n_o(ce_n),
    .we_n_o(we_n), .re_n_o(re_n), .cle_o(cle), .ale_o(ale), .io_o(io_out),
    .io_oe_o(io_oe), .io_i(io_in), .rb_i(rb)
  );

  task automatic check(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  // kind: 0 none, 1 data wr, 2 data rd, 3 cmd, 4 addr, 5 cs, 6 status
  function automatic int kind_of(input bit w, input logic [ADDR_W-1:0] a);
    if (a == 0) return w ? 1 : 2;
    if (w && a == 1) return 3;
    if (w && a == 2) return 4;
    if (w && a == A_CS) return 5;
    if (!w && a == A_ST) return 6;
    return 0;
  endfunction

  // {wait, we_n, re_n, cle, ale, oe} expected k falling edges after request
  function automatic logic [5:0] shape(input int kind, input int k);
    bit nand_c = kind >= 1 && kind <= 4;
    bit act = nand_c && k <= CYC;
    bit lo  = nand_c && k >= 2 && k <= T_LO + 1;
    return {act, !(lo && kind != 2), !(lo && kind == 2),
            act && kind == 3, act && kind == 4, act && kind != 2};
  endfunction

  task automatic access(input bit w, input logic [ADDR_W-1:0] a,
                        input logic [HOST_W-1:0] d, input bit inject);
    int kind = kind_of(w, a);
    logic [IO_W-1:0] rv = IO_W'($urandom);
    int last = (kind >= 1 && kind <= 4) ? CYC + 1 : 2;
    @(negedge clk);
    req = 1; we = w; addr = a; wdata = d;
    io_in = ~rv;
    @(negedge clk);
    req = 0;
    for (int k = 1; k <= last; k++) begin
      if (inject && k == 2) begin req = 1; we = 1; addr = A_CS; wdata = 32'd9; end
      else req = 0;
      if (kind == 2 && k == T_LO + 1) io_in = rv;
      if (kind == 2 && k == T_LO + 2) io_in = ~rv;
      check({wait_s, we_n, re_n, cle, ale, io_oe} == shape(kind, k),
            (kind == 3) ? "R3 cmd shape" : (kind == 4) ? "R4 addr shape" :
            (kind == 2) ? "R2 read shape" : (kind == 1) ? "R1 write shape" :
            "R9 no strobe R7 wait R8 oe",
            64'({wait_s, we_n, re_n, cle, ale, io_oe}), 64'(shape(kind, k)));
      if (kind == 1 || kind == 3 || kind == 4)
        if (k <= CYC) check(io_out == d[IO_W-1:0], "R1 io value", 64'(io_out), 64'(d[IO_W-1:0]));
      @(negedge clk);
    end
    req = 0;
    if (kind == 2) exp_rd = HOST_W'(rv);
    if (kind == 5 && int'(d[3:0]) < N_DEV) exp_cs = int'(d[3:0]);
    if (kind == 6) exp_rd = HOST_W'(rb);
    if (kind == 0 && !w) exp_rd = '0;
    check(rdata == exp_rd, (kind == 6) ? "R6 status" : (kind == 0) ? "R9 undef read" : "R2 rdata",
          64'(rdata), 64'(exp_rd));
    check(ce_n == ~(N_DEV'(1) << exp_cs), inject ? "R7 ignored req" : "R5 chip enable",
          64'(ce_n), 64'(~(N_DEV'(1) << exp_cs)));
  endtask

  task automatic set_rb(input logic [N_DEV-1:0] v);
    rb = v;
    repeat (3) @(negedge clk);
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog expired act=0 exp=1");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    void'($urandom(32'd4242));
    repeat (3) @(negedge clk);
    // R10 reset state
    check({wait_s, we_n, re_n, cle, ale, io_oe} == 6'b011000, "R10 strobes",
          64'({wait_s, we_n, re_n, cle, ale, io_oe}), 64'b011000);
    check(ce_n == 16'hFFFE, "R10 ce", 64'(ce_n), 64'hFFFE);
    check(rdata == 0, "R10 rdata", 64'(rdata), 0);
    rst_n = 1;
    // directed
    access(1, 28'h0, 32'hA5, 0);            // R1
    access(0, 28'h0, 32'h0, 0);             // R2
    access(1, 28'h1, 32'h70, 0);            // R3
    access(1, 28'h2, 32'h3C, 0);            // R4
    access(1, A_CS, 32'd15, 0);             // R5 top device
    set_rb(16'h8001);
    access(0, A_ST, 32'h0, 0);              // R6
    access(1, 28'h3, 32'h55, 0);            // R9 undefined write
    access(0, 28'h1, 32'h0, 0);             // R9 read of write-only offset -> 0
    access(1, 28'h1, 32'hFF, 1);            // R7 request during wait ignored
    access(1, A_CS, 32'd0, 0);              // R5 device 0
    // random
    for (int i = 0; i < 60; i++) begin
      int sel = $urandom_range(0, 7);
      logic [ADDR_W-1:0] a;
      bit w;
      if ($urandom_range(0, 3) == 0) set_rb(N_DEV'($urandom));
      case (sel)
        0: begin w = 1; a = 0; end
        1: begin w = 0; a = 0; end
        2: begin w = 1; a = 1; end
        3: begin w = 1; a = 2; end
        4: begin w = 1; a = A_CS; end
        5: begin w = 0; a = A_ST; end
        6: begin w = 0; a = A_CS; end
        default: begin w = 1'($urandom); a = ADDR_W'($urandom_range(3, 1000)); end
      endcase
      access(w, a, $urandom, 0);
    end
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule